// File: doc/BRIEF.md
# Video Memory Block-Copy DMA Engine

This engine copies data from anywhere on a 16-bit system bus into an 8 KiB video memory window. Transfers are always made of whole 16-byte blocks. Software sets the source and destination through four write-only byte registers. It then writes a control byte that holds the block count and the transfer mode. In burst mode every block moves back to back. In line mode one block moves for each pulse on the line-trigger input.

The source and destination pointers live in the programmed registers themselves. They advance by 16 after every completed block and keep that value after the transfer ends. A later transfer can therefore carry on where the last one stopped without any reprogramming. Each register byte can also be rewritten alone.

The sequencer has four states:
- IDLE: no transfer is running.
- WAIT_LINE: a line-mode transfer is waiting for a pulse.
- FETCH: a read request is on the memory port.
- STORE: a write request is on the memory port.

Its transitions are:
- start-burst: IDLE to FETCH, on a control write with bit 7 = 0.
- start-line: IDLE to WAIT_LINE, on a control write with bit 7 = 1.
- line-go: WAIT_LINE to FETCH, on a pulse.
- fetched: FETCH to STORE, on a read handshake.
- next-byte: STORE to FETCH, on a write handshake that is not the last of its block.
- block-burst: STORE to FETCH, when a block ends with blocks still left in burst mode.
- block-line: STORE to WAIT_LINE, when a block ends with blocks still left in line mode.
- finish: STORE to IDLE, when the final block ends.
- cancel: WAITLINE, FETCH or STORE to IDLE, on a control write with bit 7 = 0 during a line-mode transfer.

Top module: `vdma_copy`

## Requirements
- R1: After reset, reading the control register (select 4) returns 0xFF, and `mem_req` stays low until a transfer is started.
- R2: The source address is taken as bits 15:4 of the written pair (select 0 = high byte, select 1 = low byte). The low 4 bits are ignored and treated as zero, so the first read of a block falls on a 16-byte boundary.
- R3: From the destination pair (select 2 = high byte, select 3 = low byte), only address bits 12:4 are kept. Every write goes to 0x8000 plus that offset plus the byte index, so it lands in 0x8000 to 0x9FFF.
- R4: Each byte is moved as one read handshake followed by one write handshake, with a handshake being `mem_req` and `mem_ready` both high at a clock edge. While `mem_ready` is low, the request, its direction and its address are held. A block is exactly 16 writes at index 0 to 15.
- R5: After each completed block, both pointers advance by 16. The destination offset wraps inside its 13-bit window, so 0x9FF0 is followed by 0x8000.
- R6: The pointers keep their advanced values after a transfer ends. A new transfer with no address writes starts at the first address plus 16 times the number of blocks already moved.
- R7: Writing one byte of a pair replaces only that half. The other half keeps its current value, including any advance it has received.
- R8: A control write while idle starts a transfer. Bits 6:0 hold the block count minus one (1 to 128 blocks), and bit 7 selects line mode (1) or burst mode (0). When the last block completes, the control register reads 0xFF.
- R9: In line mode, one block moves per pulse. Pulses that arrive while a block is in progress are ignored. While the transfer is active, the control register reads bit 7 = 0 with bits 6:0 = remaining blocks minus one.
- R10: During a line-mode transfer, a control write with bit 7 = 0 cancels it at once:
  - the request drops;
  - a partly copied block is not counted, so the pointers stay at the start of that block;
  - the control register then reads 0x80 ORed with the remaining blocks minus one.
- R11: While a transfer is active, writes to the address registers are ignored. Control writes are also ignored, except for a cancel.
- R12: The four address registers are write-only and read as 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_sel | input | 3 | Register select (0 to 3 address bytes, 4 control) |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data for the selected register |
| line_pulse | input | 1 | One-cycle trigger that releases one block in line mode |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write to video memory, 0 = read from source |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid while a read is requested |
| mem_ready | input | 1 | Handshake acceptance of the current request |

## Verification
The bench builds the engine with its default parameters: an 8-bit register bus, 16-byte blocks, and destination bits 12:4 kept under a base of 0x8000. With these values the whole 8 KiB window is small enough to shadow in the bench and compare after every transfer. The full 128-block length fits in a few thousand cycles even though `mem_ready` is randomly withheld. Destination wrap at 0x9FF0 can be reached with a single directed block.

// File: rtl/vdma_pkg.sv
package vdma_pkg;

    localparam int SEL_W = 3;

    localparam logic [SEL_W-1:0] SEL_SRC_HI = 3'd0;
    localparam logic [SEL_W-1:0] SEL_SRC_LO = 3'd1;
    localparam logic [SEL_W-1:0] SEL_DST_HI = 3'd2;
    localparam logic [SEL_W-1:0] SEL_DST_LO = 3'd3;
    localparam logic [SEL_W-1:0] SEL_CTRL   = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_LINE = 2'd1,
        ST_FETCH     = 2'd2,
        ST_STORE     = 2'd3
    } vdma_state_e;

endpackage

// File: rtl/vdma_ptr.sv
// Block-granular address pointer written one byte at a time and
// advanced by one block per completed copy.
module vdma_ptr #(
    parameter int DATA_W    = 8,
    parameter int BLK_SHIFT = 4,
    parameter int HI_BIT    = 15
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_hi,
    input  logic                  wr_lo,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  adv,
    output logic [2*DATA_W-1:0]   addr
);
    localparam int AW = 2 * DATA_W;
    localparam int PW = HI_BIT - BLK_SHIFT + 1;
    localparam logic [PW-1:0] PTR_ONE = PW'(1);

    logic [PW-1:0] ptr_q;
    logic [PW-1:0] ptr_d;
    logic [AW-1:0] cand;
    logic          unused_cand;

    always_comb begin
        addr = '0;
        addr[HI_BIT:BLK_SHIFT] = ptr_q;
    end

    // Merge the written byte into the current full address, then keep
    // only the bits this pointer holds.
    always_comb begin
        cand = addr;
        if (wr_hi) cand[AW-1:DATA_W] = wdata;
        if (wr_lo) cand[DATA_W-1:0]  = wdata;
    end

    assign unused_cand = ^cand;

    always_comb begin
        ptr_d = ptr_q;
        if (wr_hi || wr_lo) ptr_d = cand[HI_BIT:BLK_SHIFT];
        else if (adv)       ptr_d = ptr_q + PTR_ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    // R7: a high-byte write leaves the low half untouched
    a_r7_hi_write_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo && !adv) |=>
            addr[DATA_W-1:BLK_SHIFT] == $past(addr[DATA_W-1:BLK_SHIFT]));

    // R5: one completed block advances the pointer by exactly one block
    a_r5_block_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_hi && !wr_lo) |=>
            addr[HI_BIT:BLK_SHIFT] == $past(addr[HI_BIT:BLK_SHIFT]) + PTR_ONE);

endmodule

// File: rtl/vdma_fsm.sv
// Transfer sequencer: block count, byte index, mode and memory phase.
module vdma_fsm
    import vdma_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int BLK_SHIFT = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctrl_wr,
    input  logic [DATA_W-1:0]     ctrl_wdata,
    input  logic                  line_pulse,
    input  logic                  mem_ready,
    output logic                  fetch_req,
    output logic                  store_req,
    output logic [BLK_SHIFT-1:0]  byte_idx,
    output logic                  blk_done,
    output logic                  active,
    output logic [DATA_W-1:0]     status
);
    localparam int LEN_W = DATA_W - 1;
    localparam logic [BLK_SHIFT-1:0] IDX_LAST = '1;
    localparam logic [BLK_SHIFT-1:0] IDX_ONE  = BLK_SHIFT'(1);
    localparam logic [LEN_W-1:0]     REM_ONE  = LEN_W'(1);

    vdma_state_e          state_q, state_d;
    logic [LEN_W-1:0]     rem_q, rem_d;
    logic [BLK_SHIFT-1:0] idx_q, idx_d;
    logic                 line_q, line_d;
    logic                 done_c;
    logic                 cancel;

    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        idx_d   = idx_q;
        line_d  = line_q;
        done_c  = 1'b0;
        cancel  = ctrl_wr && line_q && (state_q != ST_IDLE) && !ctrl_wdata[DATA_W-1];
        unique case (state_q)
            ST_IDLE: begin
                if (ctrl_wr) begin
                    rem_d   = ctrl_wdata[LEN_W-1:0];
                    line_d  = ctrl_wdata[DATA_W-1];
                    idx_d   = '0;
                    state_d = ctrl_wdata[DATA_W-1] ? ST_WAIT_LINE : ST_FETCH;
                end
            end
            ST_WAIT_LINE: begin
                if (line_pulse) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (mem_ready) state_d = ST_STORE;
            end
            ST_STORE: begin
                if (mem_ready) begin
                    if (idx_q == IDX_LAST) begin
                        done_c = 1'b1;
                        idx_d  = '0;
                        if (rem_q == '0) begin
                            rem_d   = '1;
                            state_d = ST_IDLE;
                        end else begin
                            rem_d   = rem_q - REM_ONE;
                            state_d = line_q ? ST_WAIT_LINE : ST_FETCH;
                        end
                    end else begin
                        idx_d   = idx_q + IDX_ONE;
                        state_d = ST_FETCH;
                    end
                end
            end
        endcase
        if (cancel) begin
            state_d = ST_IDLE;
            idx_d   = '0;
            rem_d   = rem_q;
            done_c  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rem_q   <= '1;
            idx_q   <= '0;
            line_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
            idx_q   <= idx_d;
            line_q  <= line_d;
        end
    end

    always_comb begin
        fetch_req = (state_q == ST_FETCH);
        store_req = (state_q == ST_STORE);
        active    = (state_q != ST_IDLE);
        byte_idx  = idx_q;
        blk_done  = done_c;
        status    = {(state_q == ST_IDLE), rem_q};
    end

    // R8: completing the final block leaves the control readback at all ones
    a_r8_final_block_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done && rem_q == '0) |=> status == {DATA_W{1'b1}});

    // R10: a cancel keeps the remaining count and sets the idle flag
    a_r10_cancel_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> (status[DATA_W-1] && status[LEN_W-1:0] == $past(rem_q)));

    // R9: the line-wait state never issues a memory request
    a_r9_wait_no_request: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_LINE && !line_pulse) |=> !fetch_req && !store_req);

endmodule

// File: rtl/vdma_copy.sv
module vdma_copy
    import vdma_pkg::*;
#(
    parameter int                    DATA_W     = 8,
    parameter int                    BLK_SHIFT  = 4,
    parameter int                    DST_HI_BIT = 12,
    parameter logic [2*DATA_W-1:0]   DST_BASE   = 16'h8000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_we,
    input  logic [2:0]            cpu_sel,
    input  logic [DATA_W-1:0]     cpu_wdata,
    output logic [DATA_W-1:0]     cpu_rdata,
    input  logic                  line_pulse,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [2*DATA_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]     mem_wdata,
    input  logic [DATA_W-1:0]     mem_rdata,
    input  logic                  mem_ready
);
    localparam int AW = 2 * DATA_W;

    logic                 fetch_req, store_req, blk_done, active;
    logic [BLK_SHIFT-1:0] byte_idx;
    logic [DATA_W-1:0]    status;
    logic [AW-1:0]        src_addr, dst_addr, idx_ext;
    logic [DATA_W-1:0]    data_q;
    logic                 addr_wr_ok, ctrl_wr;

    assign addr_wr_ok = cpu_we && !active;
    assign ctrl_wr    = cpu_we && (cpu_sel == SEL_CTRL);

    vdma_ptr #(.DATA_W(DATA_W), .BLK_SHIFT(BLK_SHIFT), .HI_BIT(AW-1)) u_src_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_hi (addr_wr_ok && cpu_sel == SEL_SRC_HI),
        .wr_lo (addr_wr_ok && cpu_sel == SEL_SRC_LO),
        .wdata (cpu_wdata),
        .adv   (blk_done),
        .addr  (src_addr)
    );

    vdma_ptr #(.DATA_W(DATA_W), .BLK_SHIFT(BLK_SHIFT), .HI_BIT(DST_HI_BIT)) u_dst_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_hi (addr_wr_ok && cpu_sel == SEL_DST_HI),
        .wr_lo (addr_wr_ok && cpu_sel == SEL_DST_LO),
        .wdata (cpu_wdata),
        .adv   (blk_done),
        .addr  (dst_addr)
    );

    vdma_fsm #(.DATA_W(DATA_W), .BLK_SHIFT(BLK_SHIFT)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (cpu_wdata),
        .line_pulse (line_pulse),
        .mem_ready  (mem_ready),
        .fetch_req  (fetch_req),
        .store_req  (store_req),
        .byte_idx   (byte_idx),
        .blk_done   (blk_done),
        .active     (active),
        .status     (status)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                     data_q <= '0;
        else if (fetch_req && mem_ready) data_q <= mem_rdata;
    end

    assign idx_ext   = AW'(byte_idx);
    assign mem_req   = fetch_req || store_req;
    assign mem_we    = store_req;
    assign mem_wdata = data_q;
    assign mem_addr  = store_req ? (DST_BASE | dst_addr | idx_ext) : (src_addr | idx_ext);
    assign cpu_rdata = (cpu_sel == SEL_CTRL) ? status : {DATA_W{1'b1}};

    // R3: every write lands inside the video window
    a_r3_dst_window: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |->
            mem_addr[AW-1:DST_HI_BIT+1] == DST_BASE[AW-1:DST_HI_BIT+1]);

    // R4: an unaccepted request is held unchanged
    a_r4_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=>
            (!mem_req || ($stable(mem_addr) && $stable(mem_we))));

    // R4: an accepted read is followed by a write unless a cancel lands
    a_r4_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ready && !(ctrl_wr && !cpu_wdata[DATA_W-1]))
            |=> (mem_req && mem_we));

    // R2: the access after a block's last write starts on a block boundary
    a_r2_block_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ready && mem_addr[BLK_SHIFT-1:0] == '1)
            |=> (!mem_req || mem_addr[BLK_SHIFT-1:0] == '0));

endmodule

// File: tb/vdma_copy_bench.sv
`timescale 1ns/1ps
module vdma_copy_bench;

    localparam logic [2:0] S_SRC_HI = 3'd0;
    localparam logic [2:0] S_SRC_LO = 3'd1;
    localparam logic [2:0] S_DST_HI = 3'd2;
    localparam logic [2:0] S_DST_LO = 3'd3;
    localparam logic [2:0] S_CTRL   = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_we = 1'b0;
    logic [2:0]  cpu_sel = S_CTRL;
    logic [7:0]  cpu_wdata = 8'h00;
    logic [7:0]  cpu_rdata;
    logic        line_pulse = 1'b0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_ready = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int wr_count = 0;
    int oob_count = 0;
    logic [7:0]  vram     [0:8191];
    logic [7:0]  exp_vram [0:8191];
    logic [15:0] m_src = 16'h0000;
    logic [12:0] m_dst = 13'h0000;

    always #2.5 clk = ~clk;

    vdma_copy u_vdma_copy (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_sel(cpu_sel),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .line_pulse(line_pulse),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    function automatic logic [7:0] src_pat(input logic [15:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
    endfunction

    assign mem_rdata = src_pat(mem_addr);

    always @(negedge clk) mem_ready <= rst_n && (($urandom % 4) != 0);

    always @(posedge clk) begin
        if (rst_n && mem_req && mem_we && mem_ready) begin
            vram[mem_addr[12:0]] <= mem_wdata;
            wr_count <= wr_count + 1;
            if (mem_addr[15:13] != 3'b100) oob_count <= oob_count + 1;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        cpu_sel = s; cpu_wdata = d; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic cpu_read(input logic [2:0] s, output logic [7:0] v);
        @(negedge clk);
        cpu_sel = s;
        #1 v = cpu_rdata;
    endtask

    // Address write while idle: applies the requirement rules to the model.
    task automatic set_addr(input logic [2:0] s, input logic [7:0] d);
        cpu_write(s, d);
        case (s)
            S_SRC_HI: m_src[15:8] = d;
            S_SRC_LO: m_src[7:4]  = d[7:4];
            S_DST_HI: m_dst[12:8] = d[4:0];
            S_DST_LO: m_dst[7:4]  = d[7:4];
            default: ;
        endcase
    endtask

    task automatic model_copy(input int n);
        for (int b = 0; b < n; b++) begin
            for (int i = 0; i < 16; i++)
                exp_vram[m_dst + 13'(i)] = src_pat(m_src + 16'(i));
            m_src = m_src + 16'h0010;
            m_dst = m_dst + 13'h0010;
        end
    endtask

    task automatic chk_vram(input string req);
        int mism = 0;
        for (int i = 0; i < 8192; i++)
            if (vram[i] !== exp_vram[i]) mism++;
        chk(req, "video memory mismatches", mism, 0);
    endtask

    task automatic wait_done(input string req);
        logic [7:0] r = 8'h00;
        int guard = 0;
        while (r != 8'hFF && guard < 20000) begin
            cpu_read(S_CTRL, r);
            guard++;
        end
        chk(req, "control after finish", int'(r), 8'hFF);
    endtask

    task automatic wait_writes(input int target);
        int guard = 0;
        while (wr_count < target && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic pulse();
        @(negedge clk);
        line_pulse = 1'b1;
        @(negedge clk);
        line_pulse = 1'b0;
    endtask

    task automatic run_burst(input int n, input string req);
        int base = wr_count;
        cpu_write(S_CTRL, 8'(n - 1));
        wait_done(req);
        model_copy(n);
        chk_vram(req);
        chk("R4", "write handshakes", wr_count - base, 16 * n);
    endtask

    task automatic run_line(input int n, input string req);
        int base = wr_count;
        cpu_write(S_CTRL, 8'h80 | 8'(n - 1));
        for (int b = 0; b < n; b++) begin
            pulse();
            wait_writes(base + 16 * (b + 1));
        end
        wait_done(req);
        model_copy(n);
        chk_vram(req);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] r;
        int base;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8192; i++) begin
            vram[i] = 8'h00;
            exp_vram[i] = 8'h00;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        cpu_read(S_CTRL, r);
        chk("R1", "control after reset", int'(r), 8'hFF);
        chk("R1", "mem_req after reset", int'(mem_req), 0);
        // R12: address registers are write-only
        cpu_read(S_SRC_HI, r);
        chk("R12", "source high readback", int'(r), 8'hFF);
        cpu_read(S_DST_LO, r);
        chk("R12", "destination low readback", int'(r), 8'hFF);

        // R2, R3: unaligned source, destination at the top of the window
        set_addr(S_SRC_HI, 8'h12);
        set_addr(S_SRC_LO, 8'h37);
        set_addr(S_DST_HI, 8'hFF);
        set_addr(S_DST_LO, 8'hFF);
        run_burst(1, "R2");
        chk("R3", "writes outside window", oob_count, 0);

        // R5, R6: continue without rewriting, destination wraps to the bottom
        run_burst(2, "R6");
        chk("R5", "model destination after wrap", int'(m_dst), 13'h0020);

        // R7: half writes keep the advanced other half
        set_addr(S_SRC_LO, 8'h80);
        set_addr(S_DST_HI, 8'h03);
        run_burst(1, "R7");

        // R11: writes during an active burst are ignored
        base = wr_count;
        cpu_write(S_CTRL, 8'h03);
        cpu_write(S_SRC_HI, 8'h55);
        cpu_write(S_CTRL, 8'h05);
        cpu_read(S_CTRL, r);
        chk("R11", "control bit 7 during burst", int'(r[7]), 0);
        wait_done("R11");
        model_copy(4);
        chk_vram("R11");
        chk("R11", "write handshakes", wr_count - base, 64);
        run_burst(1, "R11");

        // R9: line mode, stray pulses ignored
        base = wr_count;
        cpu_write(S_CTRL, 8'h82);
        repeat (12) @(negedge clk);
        chk("R9", "writes before first pulse", wr_count - base, 0);
        cpu_read(S_CTRL, r);
        chk("R9", "control before first pulse", int'(r), 8'h02);
        pulse();
        wait_writes(base + 16);
        cpu_read(S_CTRL, r);
        chk("R9", "control after one block", int'(r), 8'h01);
        pulse();
        repeat (3) @(negedge clk);
        pulse();
        wait_writes(base + 32);
        repeat (20) @(negedge clk);
        chk("R9", "writes after mid-block pulse", wr_count - base, 32);
        cpu_read(S_CTRL, r);
        chk("R9", "control after two blocks", int'(r), 8'h00);
        pulse();
        wait_done("R9");
        model_copy(3);
        chk_vram("R9");

        // R10: cancel in the middle of the second block
        base = wr_count;
        cpu_write(S_CTRL, 8'h83);
        pulse();
        wait_writes(base + 16);
        pulse();
        repeat (6) @(negedge clk);
        cpu_write(S_CTRL, 8'h00);
        cpu_read(S_CTRL, r);
        chk("R10", "control after cancel", int'(r), 8'h82);
        model_copy(1);
        repeat (10) @(negedge clk);
        chk("R10", "mem_req after cancel", int'(mem_req), 0);
        run_burst(1, "R10");

        // R8: maximum length burst
        set_addr(S_SRC_HI, 8'hA0);
        set_addr(S_SRC_LO, 8'h00);
        set_addr(S_DST_HI, 8'h08);
        set_addr(S_DST_LO, 8'h00);
        run_burst(128, "R8");

        // Random mix of partial address writes, lengths and modes
        for (int it = 0; it < 30; it++) begin
            if ($urandom % 2) set_addr(S_SRC_HI, 8'($urandom));
            if ($urandom % 2) set_addr(S_SRC_LO, 8'($urandom));
            if ($urandom % 2) set_addr(S_DST_HI, 8'($urandom));
            if ($urandom % 2) set_addr(S_DST_LO, 8'($urandom));
            if ($urandom % 3 == 0) run_line(1 + int'($urandom % 4), "R9");
            else                   run_burst(1 + int'($urandom % 8), "R6");
        end
        chk("R3", "writes outside window", oob_count, 0);

        summary();
        $finish;
    end

endmodule